// File: doc/BRIEF.md
# Supervisor-Level Interrupt Trap Arbiter

This block decides, once per cycle, whether any pending interrupt should trap to the host-supervisor level, and which interrupt wins when more than one is eligible. Interrupt requests arrive on two separate pending/enable pairs. One pair is the supervisor's own. The other is the hypervisor pair, which carries guest and guest-external interrupts. A bit is a candidate when it is both pending and enabled in either pair. Any bit set in the delegation vector is withdrawn, because that interrupt belongs to the guest.

Trapping is gated by the current privilege mode and by the supervisor global enable. The surviving candidates are resolved in a fixed order that is not numeric, in which supervisor and guest interrupts interleave. The block reports a take-trap flag and the bit index of the winner, which serves as its cause number. The decision logic is purely combinational. By default a register stage sits at the output; a parameter can remove it.

Top module: `hs_irq_arbiter`

## Requirements
- R1: With mode code 2'b11 (machine) or the unused code 2'b10 on `priv_mode`, `take_trap` stays 0 whatever the pending state.
- R2: With mode code 2'b01 (host-supervisor), a trap is taken only while `sup_gie` is 1.
- R3: With mode code 2'b00 (less privileged), a trap is taken whatever the value of `sup_gie`.
- R4: Bit i is a candidate when `s_pend[i]&s_en[i]` or `h_pend[i]&h_en[i]` is 1. A bit that is pending but not enabled in its own pair is not a candidate.
- R5: A candidate whose bit is set in `h_deleg` is excluded.
- R6: Among candidates, priority from highest to lowest is bit 9, bit 1, bit 5, bit 12, bit 10, bit 2, bit 6.
- R7: `cause` carries the 6-bit index of the winning bit (9, 1, 5, 12, 10, 2 or 6).
- R8: When no candidate survives, or the mode forbids trapping, `take_trap` is 0 and `cause` is 0.
- R9: Pending and enable bits at indices other than the seven listed in R6 have no effect on the outputs.
- R10: With `REG_OUT=1` (the default), both outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 2 | Current privilege mode: 00 lower, 01 host-supervisor, 10 unused, 11 machine |
| sup_gie | input | 1 | Supervisor global interrupt enable |
| s_pend | input | VEC_W | Supervisor pending vector |
| s_en | input | VEC_W | Supervisor enable vector |
| h_pend | input | VEC_W | Hypervisor pending vector |
| h_en | input | VEC_W | Hypervisor enable vector |
| h_deleg | input | VEC_W | Delegation vector; set bits are withdrawn |
| take_trap | output | 1 | A trap to host-supervisor is due |
| cause | output | 6 | Index of the winning interrupt; 0 when no trap |

## Verification
With the default output register, every result is due one rising edge after its inputs are applied. The bench changes inputs on the falling edge, waits through the next rising edge, and samples on the falling edge that follows. One check applies new inputs and samples before the capturing edge, and expects the previous result, which confirms that the registered output does not change early. Reset is checked with the same timing: the outputs must read zero at the first falling edge after the reset edge.

// File: rtl/hs_irq_pkg.sv
package hs_irq_pkg;

    typedef enum logic [1:0] {
        PRIV_LOWER = 2'b00,
        PRIV_HOST  = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    localparam int NUM_SRC = 7;
    localparam int CAUSE_W = 6;
    localparam int MIN_W   = 13;

    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
    } arb_out_t;

    // Bit index served at priority rank k (rank 0 is highest).
    function automatic int rank_bit(input int k);
        case (k)
            0:       return 9;
            1:       return 1;
            2:       return 5;
            3:       return 12;
            4:       return 10;
            5:       return 2;
            default: return 6;
        endcase
    endfunction

    // Mask of all bits that take part in arbitration.
    function automatic logic [31:0] src_mask();
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < NUM_SRC; k++) m[rank_bit(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/hs_trap_permit.sv
module hs_trap_permit
    import hs_irq_pkg::*;
(
    input  logic [1:0] priv_mode,
    input  logic       sup_gie,
    output logic       permit
);
    priv_e mode;
    assign mode = priv_e'(priv_mode);

    always_comb begin
        case (mode)
            PRIV_LOWER: permit = 1'b1;
            PRIV_HOST:  permit = sup_gie;
            default:    permit = 1'b0;
        endcase
    end
endmodule

// File: rtl/hs_cand_build.sv
module hs_cand_build
    import hs_irq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic [VEC_W-1:0] s_pend,
    input  logic [VEC_W-1:0] s_en,
    input  logic [VEC_W-1:0] h_pend,
    input  logic [VEC_W-1:0] h_en,
    input  logic [VEC_W-1:0] h_deleg,
    output logic [VEC_W-1:0] cand
);
    localparam logic [31:0]      FULL_MASK = src_mask();
    localparam logic [VEC_W-1:0] MASK      = FULL_MASK[VEC_W-1:0];

    logic [VEC_W-1:0] s_hit;
    logic [VEC_W-1:0] h_hit;

    assign s_hit = s_pend & s_en;
    assign h_hit = h_pend & h_en;
    assign cand  = (s_hit | h_hit) & ~h_deleg & MASK;
endmodule

// File: rtl/hs_prio_pick.sv
module hs_prio_pick
    import hs_irq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic [VEC_W-1:0]   cand,
    output logic               found,
    output logic [CAUSE_W-1:0] cause,
    output logic [NUM_SRC-1:0] grant
);
    logic [NUM_SRC-1:0] hit;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_rank
        localparam int B = rank_bit(k);
        assign hit[k] = cand[B];
    end

    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        cause = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            grant[k] = hit[k] & ~seen;
            seen     = seen | hit[k];
            if (grant[k]) cause = CAUSE_W'(rank_bit(k));
        end
        found = seen;
    end

    always_comb begin
        a_r6_single_winner: assert ($onehot0(grant));
        if (found) begin
            a_r7_winner_is_candidate: assert (cand[cause] == 1'b1);
        end
    end
endmodule

// File: rtl/hs_irq_arbiter.sv
module hs_irq_arbiter
    import hs_irq_pkg::*;
#(
    parameter int VEC_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       priv_mode,
    input  logic             sup_gie,
    input  logic [VEC_W-1:0] s_pend,
    input  logic [VEC_W-1:0] s_en,
    input  logic [VEC_W-1:0] h_pend,
    input  logic [VEC_W-1:0] h_en,
    input  logic [VEC_W-1:0] h_deleg,
    output logic             take_trap,
    output logic [5:0]       cause
);
    initial begin
        a_width_ok: assert (VEC_W >= MIN_W && VEC_W <= 32);
    end

    logic               permit;
    logic [VEC_W-1:0]   cand;
    logic               found;
    logic [CAUSE_W-1:0] pick_cause;
    logic [NUM_SRC-1:0] grant;
    arb_out_t           nxt;
    arb_out_t           cur;

    hs_trap_permit u_permit (
        .priv_mode (priv_mode),
        .sup_gie   (sup_gie),
        .permit    (permit)
    );

    hs_cand_build #(.VEC_W(VEC_W)) u_cand (
        .s_pend  (s_pend),
        .s_en    (s_en),
        .h_pend  (h_pend),
        .h_en    (h_en),
        .h_deleg (h_deleg),
        .cand    (cand)
    );

    hs_prio_pick #(.VEC_W(VEC_W)) u_pick (
        .cand  (cand),
        .found (found),
        .cause (pick_cause),
        .grant (grant)
    );

    always_comb begin
        nxt.take  = permit & found;
        nxt.cause = nxt.take ? pick_cause : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end

        a_r1_machine_blocks: assert property (@(posedge clk) disable iff (rst)
            (priv_mode[1] == 1'b1) |=> !take_trap);
        a_r2_gie_gates_host: assert property (@(posedge clk) disable iff (rst)
            (priv_mode == 2'b01 && !sup_gie) |=> !take_trap);
        a_r5_delegated_never_wins: assert property (@(posedge clk) disable iff (rst)
            (found && h_deleg[pick_cause]) |-> 1'b0);
        a_r8_idle_cause_zero: assert property (@(posedge clk) disable iff (rst)
            !take_trap |-> (cause == '0));
    end else begin : g_comb
        assign cur = nxt;

        always_comb begin
            if (!take_trap) begin
                a_r8_idle_cause_zero_c: assert (cause == '0);
            end
        end
    end

    assign take_trap = cur.take;
    assign cause     = cur.cause;
endmodule

// File: tb/sim_hs_irq_arbiter.sv
module sim_hs_irq_arbiter;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   priv_mode;
    logic         sup_gie;
    logic [W-1:0] s_pend, s_en, h_pend, h_en, h_deleg;
    logic         take_trap;
    logic [5:0]   cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hs_irq_arbiter #(.VEC_W(W), .REG_OUT(1'b1)) u0 (
        .clk (clk), .rst (rst), .priv_mode (priv_mode), .sup_gie (sup_gie),
        .s_pend (s_pend), .s_en (s_en), .h_pend (h_pend), .h_en (h_en),
        .h_deleg (h_deleg), .take_trap (take_trap), .cause (cause)
    );

    task automatic check(input logic et, input logic [5:0] ec, input string tag);
        checks++;
        if (take_trap !== et || cause !== ec) begin
            errors++;
            $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                     tag, take_trap, cause, et, ec);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic g,
                         input logic [W-1:0] sp, input logic [W-1:0] se,
                         input logic [W-1:0] hp, input logic [W-1:0] he,
                         input logic [W-1:0] dg);
        priv_mode = m; sup_gie = g; s_pend = sp; s_en = se;
        h_pend = hp; h_en = he; h_deleg = dg;
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [W-1:0] S_BITS = 16'h0222;  // 9, 5, 1
    localparam logic [W-1:0] H_BITS = 16'h1444;  // 12, 10, 6, 2

    task automatic t_reset();
        rst = 1'b1;
        apply(2'b00, 1'b1, S_BITS, S_BITS, H_BITS, H_BITS, '0);
        check(1'b0, 6'd0, "R10 reset");
        rst = 1'b0;
    endtask

    task automatic t_machine();
        apply(2'b11, 1'b1, S_BITS, S_BITS, H_BITS, H_BITS, '0);
        check(1'b0, 6'd0, "R1 machine");
        apply(2'b10, 1'b1, S_BITS, S_BITS, H_BITS, H_BITS, '0);
        check(1'b0, 6'd0, "R1 unused code");
    endtask

    task automatic t_host();
        apply(2'b01, 1'b0, 16'h0200, 16'h0200, '0, '0, '0);
        check(1'b0, 6'd0, "R2 host gie=0");
        apply(2'b01, 1'b1, 16'h0200, 16'h0200, '0, '0, '0);
        check(1'b1, 6'd9, "R2 host gie=1");
    endtask

    task automatic t_lower();
        apply(2'b00, 1'b0, 16'h0200, 16'h0200, '0, '0, '0);
        check(1'b1, 6'd9, "R3 lower gie=0");
    endtask

    task automatic t_cand();
        apply(2'b00, 1'b1, S_BITS, '0, H_BITS, '0, '0);
        check(1'b0, 6'd0, "R4 pending not enabled");
        apply(2'b00, 1'b1, '0, '0, 16'h0400, 16'h0400, '0);
        check(1'b1, 6'd10, "R4 hyp pair");
        apply(2'b00, 1'b1, 16'h0002, 16'h0002, '0, '0, '0);
        check(1'b1, 6'd1, "R4 sup pair");
        apply(2'b00, 1'b1, 16'h0020, 16'h0000, 16'h0000, 16'h0020, '0);
        check(1'b0, 6'd0, "R4 cross pair not a candidate");
    endtask

    task automatic t_deleg();
        apply(2'b00, 1'b1, 16'h0202, 16'h0202, '0, '0, 16'h0200);
        check(1'b1, 6'd1, "R5 delegated bit skipped");
        apply(2'b00, 1'b1, S_BITS, S_BITS, H_BITS, H_BITS, 16'hFFFF);
        check(1'b0, 6'd0, "R8 all delegated");
    endtask

    task automatic t_prio();
        logic [W-1:0] sp;
        logic [W-1:0] hp;
        int exp [7] = '{9, 1, 5, 12, 10, 2, 6};
        sp = S_BITS; hp = H_BITS;
        for (int k = 0; k < 7; k++) begin
            apply(2'b00, 1'b1, sp, S_BITS, hp, H_BITS, '0);
            check(1'b1, 6'(exp[k]), "R6 R7 priority walk");
            sp[exp[k]] = 1'b0;
            hp[exp[k]] = 1'b0;
        end
        apply(2'b00, 1'b1, sp, S_BITS, hp, H_BITS, '0);
        check(1'b0, 6'd0, "R8 none left");
    endtask

    task automatic t_ignored();
        apply(2'b00, 1'b1, 16'hE999, 16'hE999, 16'hE999, 16'hE999, '0);
        check(1'b0, 6'd0, "R9 unused bits alone");
        apply(2'b00, 1'b1, 16'hE999 | 16'h0004, 16'hE999, 16'hE999, 16'hE999 | 16'h0004, '0);
        check(1'b0, 6'd0, "R9 unused bits plus split bit 2");
        apply(2'b00, 1'b1, 16'hE999, 16'hE999, 16'hE9DD, 16'hE9DD, '0);
        check(1'b1, 6'd2, "R9 unused bits do not outrank bit 2");
    endtask

    task automatic t_latency();
        apply(2'b00, 1'b1, 16'h0020, 16'h0020, '0, '0, '0);
        check(1'b1, 6'd5, "R10 settled");
        s_pend = 16'h0000; h_pend = 16'h0040; h_en = 16'h0040;
        #5;
        check(1'b1, 6'd5, "R10 holds before edge");
        @(posedge clk);
        @(negedge clk);
        check(1'b1, 6'd6, "R10 updates after edge");
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        priv_mode = 2'b11; sup_gie = 1'b0;
        s_pend = '0; s_en = '0; h_pend = '0; h_en = '0; h_deleg = '0;
        @(negedge clk);
        t_reset();
        t_machine();
        t_host();
        t_lower();
        t_cand();
        t_deleg();
        t_prio();
        t_ignored();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule